// File: doc/BRIEF.md
# Floating Sample Codec for Delay Memory

This block converts audio samples between a 24-bit two's-complement fixed-point form and a 16-bit floating word that is compact enough for delay-line storage. The compress direction counts how many leading bits of the sample merely repeat the sign. It turns that count into an exponent, capped at twelve, and keeps the eleven bits that follow the sign pair as the mantissa. The expand direction rebuilds a sign-extended 24-bit sample from the word. It restores the hidden bit as the complement of the sign, except for words whose exponent is above eleven.

Each direction has its own port pair: a valid strobe with data going in, and a registered result with its own valid flag coming out one clock later. The two directions work independently, so a sample can be compressed while a stored word is expanded in the same cycle. Memory addressing and raw (non-floating) storage are handled by the surrounding memory interface and are not part of this block.

Top module: `fp_codec`

## Requirements
- R1: While `rst_n` is low at a rising edge, both valid outputs and both data outputs are cleared to zero at that edge.
- R2: Each valid output equals its valid input from the previous rising edge, giving a latency of exactly one cycle in each direction.
- R3: Bit 15 of the compressed word equals bit 23 of the sample.
- R4: Bits 14..11 of the compressed word hold the exponent. The exponent is the number of bit positions k, counted downward from bit 23, for which bits 23-k and 22-k of the sample are equal, stopping at the first unequal pair, and capped at 12. Equivalently, it is the largest k up to 12 for which the sample lies in [-2^(23-k), 2^(23-k)-1].
- R5: For an exponent e below 12, bits 10..0 of the word are bits 21..11 of the sample shifted left by e places.
- R6: For an exponent of 12, bits 10..0 of the word are bits 10..0 of the sample.
- R7: For a word with sign s, exponent e of 11 or less and mantissa m, the expanded sample is the 24-bit pattern {s, not s, m, eleven zeros} shifted right arithmetically by e places.
- R8: For a word whose exponent is 12 to 15, the expanded sample is the pattern {s, s, m, eleven zeros} shifted right arithmetically by 11 places.
- R9: When a valid input is low at a rising edge, the data output of that direction keeps its previous value.
- R10: Compressing any sample and then expanding the word returns the sample with its lowest 11-e bits cleared when e is below 11, and returns it unchanged when e is 11 or 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_vld_i | input | 1 | Sample on `cmp_smp_i` is to be compressed |
| cmp_smp_i | input | 24 | Two's-complement sample to compress |
| cmp_vld_o | output | 1 | `cmp_word_o` was loaded at the last edge |
| cmp_word_o | output | 16 | Floating word: sign 15, exponent 14..11, mantissa 10..0 |
| exp_vld_i | input | 1 | Word on `exp_word_i` is to be expanded |
| exp_word_i | input | 16 | Floating word to expand |
| exp_vld_o | output | 1 | `exp_smp_o` was loaded at the last edge |
| exp_smp_o | output | 24 | Expanded two's-complement sample |

## Verification
The bench builds the codec with its default parameters: a 24-bit sample, an 11-bit mantissa, a 4-bit exponent and a cap of 12. With this configuration the whole 16-bit word space fits within the run, so the expand side is swept over all 65,536 words, including the exponents 12 to 15 that take the clamped path. On the compress side the bench sends every power of two and its neighbours in both signs, zero and both full-scale values, plus sixteen thousand pseudo-random samples that are shifted down so that every exponent from 0 to 12 is reached. Each of these compressed words is then expanded again to check the round trip.

// File: rtl/fp_codec_pkg.sv
// Package fp_codec_pkg
// Holds the default geometry of the floating sample format that the codec
// and its submodules share. Assumes a word of sign, exponent, mantissa.
package fp_codec_pkg;
    localparam int SMP_W_DEF   = 24;  // fixed-point sample width
    localparam int MANT_W_DEF  = 11;  // mantissa width
    localparam int EXP_W_DEF   = 4;   // exponent field width
    localparam int EXP_CAP_DEF = 12;  // largest exponent produced
endpackage

// File: rtl/fp_sign_run.sv
// Module fp_sign_run
// Counts the leading bits of a two's-complement value that repeat the bit
// above them, starting at the MSB, and stops at EXP_CAP. Assumes
// EXP_CAP < SMP_W and that EXP_CAP fits in EXP_W bits.
module fp_sign_run #(
    parameter int SMP_W   = fp_codec_pkg::SMP_W_DEF,
    parameter int EXP_W   = fp_codec_pkg::EXP_W_DEF,
    parameter int EXP_CAP = fp_codec_pkg::EXP_CAP_DEF
) (
    input  logic [SMP_W-1:0] smp_i,
    output logic [EXP_W-1:0] run_o
);
    // bit i is set where bit i differs from bit i-1
    logic [SMP_W-1:0] diff;
    // run[k] is set when the first k+1 positions all repeat their neighbour
    logic [EXP_CAP-1:0] run;

    assign diff = smp_i ^ {smp_i[SMP_W-2:0], 1'b0};

    genvar k;
    generate
        for (k = 0; k < EXP_CAP; k++) begin : g_run
            if (k == 0) begin : g_first
                assign run[k] = ~diff[SMP_W-1];
            end else begin : g_next
                assign run[k] = run[k-1] & ~diff[SMP_W-1-k];
            end
        end
    endgenerate

    // Sum the prefix flags into the exponent
    always_comb begin
        run_o = '0;
        for (int i = 0; i < EXP_CAP; i++) begin
            run_o = run_o + EXP_W'(run[i]);
        end
    end
endmodule

// File: rtl/fp_pack_core.sv
// Module fp_pack_core
// Combinational compressor from a fixed-point sample to a floating word.
// Assumes the mantissa sits just under the two top bits of the sample after
// normalisation, i.e. SMP_W - 2 - MANT_W >= 0.
module fp_pack_core #(
    parameter int SMP_W   = fp_codec_pkg::SMP_W_DEF,
    parameter int MANT_W  = fp_codec_pkg::MANT_W_DEF,
    parameter int EXP_W   = fp_codec_pkg::EXP_W_DEF,
    parameter int EXP_CAP = fp_codec_pkg::EXP_CAP_DEF,
    localparam int WRD_W  = 1 + EXP_W + MANT_W
) (
    input  logic [SMP_W-1:0] smp_i,
    output logic [WRD_W-1:0] word_o
);
    localparam logic [EXP_W-1:0] CAP_E = EXP_W'(EXP_CAP);

    logic [EXP_W-1:0]  expo;
    logic [SMP_W-1:0]  norm;
    logic [MANT_W-1:0] mant;

    fp_sign_run #(
        .SMP_W  (SMP_W),
        .EXP_W  (EXP_W),
        .EXP_CAP(EXP_CAP)
    ) u_run (
        .smp_i(smp_i),
        .run_o(expo)
    );

    // Normalise: move the first significant bit up to just under the sign
    assign norm = smp_i << expo;

    // Choose the mantissa source depending on whether the count saturated
    always_comb begin
        if (expo == CAP_E) begin
            mant = smp_i[MANT_W-1:0];
        end else begin
            mant = norm[SMP_W-3 -: MANT_W];
        end
    end

    assign word_o = {smp_i[SMP_W-1], expo, mant};
endmodule

// File: rtl/fp_unpack_core.sv
// Module fp_unpack_core
// Combinational expander from a floating word to a fixed-point sample.
// Assumes the word layout of fp_pack_core; exponents above EXP_CAP-1 are
// treated as EXP_CAP-1 with the hidden bit equal to the sign.
module fp_unpack_core #(
    parameter int SMP_W   = fp_codec_pkg::SMP_W_DEF,
    parameter int MANT_W  = fp_codec_pkg::MANT_W_DEF,
    parameter int EXP_W   = fp_codec_pkg::EXP_W_DEF,
    parameter int EXP_CAP = fp_codec_pkg::EXP_CAP_DEF,
    localparam int WRD_W  = 1 + EXP_W + MANT_W
) (
    input  logic [WRD_W-1:0] word_i,
    output logic [SMP_W-1:0] smp_o
);
    localparam int PAD_W = SMP_W - 2 - MANT_W;
    localparam logic [EXP_W-1:0] TOP_E = EXP_W'(EXP_CAP - 1);

    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [MANT_W-1:0] mant;
    logic              big_e;
    logic [EXP_W-1:0]  sh;
    logic [SMP_W-1:0]  pattern;

    assign sgn  = word_i[WRD_W-1];
    assign expo = word_i[WRD_W-2 -: EXP_W];
    assign mant = word_i[MANT_W-1:0];

    // Flag the clamped exponent range
    assign big_e = (expo > TOP_E);
    assign sh    = big_e ? TOP_E : expo;

    // Rebuild the sample: sign, hidden bit, mantissa, zero padding
    assign pattern = {sgn, big_e ? sgn : ~sgn, mant, {PAD_W{1'b0}}};

    // Denormalise by an arithmetic right shift
    assign smp_o = SMP_W'($signed(pattern) >>> sh);
endmodule

// File: rtl/fp_codec.sv
// Module fp_codec
// Two independent one-cycle registered paths: compress a fixed-point sample
// to a floating word, and expand a floating word back to a sample. Data
// registers load only on valid and hold otherwise. Synchronous active-low
// reset clears every register.
module fp_codec #(
    parameter int SMP_W   = fp_codec_pkg::SMP_W_DEF,
    parameter int MANT_W  = fp_codec_pkg::MANT_W_DEF,
    parameter int EXP_W   = fp_codec_pkg::EXP_W_DEF,
    parameter int EXP_CAP = fp_codec_pkg::EXP_CAP_DEF,
    localparam int WRD_W  = 1 + EXP_W + MANT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_vld_i,
    input  logic [SMP_W-1:0] cmp_smp_i,
    output logic             cmp_vld_o,
    output logic [WRD_W-1:0] cmp_word_o,
    input  logic             exp_vld_i,
    input  logic [WRD_W-1:0] exp_word_i,
    output logic             exp_vld_o,
    output logic [SMP_W-1:0] exp_smp_o
);
    logic [WRD_W-1:0] cmp_word_d;
    logic [SMP_W-1:0] exp_smp_d;

    fp_pack_core #(
        .SMP_W  (SMP_W),
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .EXP_CAP(EXP_CAP)
    ) u_pack (
        .smp_i (cmp_smp_i),
        .word_o(cmp_word_d)
    );

    fp_unpack_core #(
        .SMP_W  (SMP_W),
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W),
        .EXP_CAP(EXP_CAP)
    ) u_unpack (
        .word_i(exp_word_i),
        .smp_o (exp_smp_d)
    );

    // Compress path output register with its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_vld_o  <= 1'b0;
            cmp_word_o <= '0;
        end else begin
            cmp_vld_o <= cmp_vld_i;
            if (cmp_vld_i) begin
                cmp_word_o <= cmp_word_d;
            end
        end
    end

    // Expand path output register with its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_vld_o <= 1'b0;
            exp_smp_o <= '0;
        end else begin
            exp_vld_o <= exp_vld_i;
            if (exp_vld_i) begin
                exp_smp_o <= exp_smp_d;
            end
        end
    end
endmodule

// File: rtl/fp_codec_chk.sv
// Module fp_codec_chk
// Temporal checks on the ports of fp_codec, attached by bind.
module fp_codec_chk #(
    parameter int SMP_W   = fp_codec_pkg::SMP_W_DEF,
    parameter int MANT_W  = fp_codec_pkg::MANT_W_DEF,
    parameter int EXP_W   = fp_codec_pkg::EXP_W_DEF,
    parameter int EXP_CAP = fp_codec_pkg::EXP_CAP_DEF,
    localparam int WRD_W  = 1 + EXP_W + MANT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_vld_i,
    input logic [SMP_W-1:0] cmp_smp_i,
    input logic             cmp_vld_o,
    input logic [WRD_W-1:0] cmp_word_o,
    input logic             exp_vld_i,
    input logic [WRD_W-1:0] exp_word_i,
    input logic             exp_vld_o,
    input logic [SMP_W-1:0] exp_smp_o
);
    localparam int TOPS = SMP_W - MANT_W;

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!cmp_vld_o && !exp_vld_o && cmp_word_o == '0 && exp_smp_o == '0)); // R1
    AST_CMP_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n) cmp_vld_i |=> cmp_vld_o); // R2
    AST_CMP_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cmp_vld_i |=> !cmp_vld_o); // R2
    AST_EXP_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n) exp_vld_i |=> exp_vld_o); // R2
    AST_CMP_SIGN: assert property (@(posedge clk) disable iff (!rst_n) cmp_vld_i |=> cmp_word_o[WRD_W-1] == $past(cmp_smp_i[SMP_W-1])); // R3
    AST_CMP_EXP_CAP: assert property (@(posedge clk) disable iff (!rst_n) cmp_vld_o |-> (32'(cmp_word_o[WRD_W-2 -: EXP_W]) <= EXP_CAP)); // R4
    AST_CMP_SMALL_MANT: assert property (@(posedge clk) disable iff (!rst_n) (cmp_vld_i && (cmp_smp_i[SMP_W-1 -: TOPS] == '0 || cmp_smp_i[SMP_W-1 -: TOPS] == '1)) |=> cmp_word_o[MANT_W-1:0] == $past(cmp_smp_i[MANT_W-1:0])); // R6
    AST_EXP_SIGN: assert property (@(posedge clk) disable iff (!rst_n) exp_vld_i |=> exp_smp_o[SMP_W-1] == $past(exp_word_i[WRD_W-1])); // R7
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cmp_vld_i |=> $stable(cmp_word_o)); // R9
    AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !exp_vld_i |=> $stable(exp_smp_o)); // R9
endmodule

bind fp_codec fp_codec_chk #(
    .SMP_W  (SMP_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W),
    .EXP_CAP(EXP_CAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_vld_i (cmp_vld_i),
    .cmp_smp_i (cmp_smp_i),
    .cmp_vld_o (cmp_vld_o),
    .cmp_word_o(cmp_word_o),
    .exp_vld_i (exp_vld_i),
    .exp_word_i(exp_word_i),
    .exp_vld_o (exp_vld_o),
    .exp_smp_o (exp_smp_o)
);

// File: tb/fp_codec_test.sv
// Bench fp_codec_test
// Sweeps the expand path over every word and the compress path over edge
// and pseudo-random samples, with expected values worked out arithmetically.
module fp_codec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_vld_i = 1'b0;
    logic [23:0] cmp_smp_i = '0;
    logic        cmp_vld_o;
    logic [15:0] cmp_word_o;
    logic        exp_vld_i = 1'b0;
    logic [15:0] exp_word_i = '0;
    logic        exp_vld_o;
    logic [23:0] exp_smp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    fp_codec uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_vld_i (cmp_vld_i),
        .cmp_smp_i (cmp_smp_i),
        .cmp_vld_o (cmp_vld_o),
        .cmp_word_o(cmp_word_o),
        .exp_vld_i (exp_vld_i),
        .exp_word_i(exp_word_i),
        .exp_vld_o (exp_vld_o),
        .exp_smp_o (exp_smp_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Exponent: largest k <= 12 with x in [-2^(23-k), 2^(23-k)-1]
    function automatic int exp_of(input int x);
        for (int k = 12; k >= 0; k--) begin
            if (x >= -(1 <<< (23 - k)) && x <= (1 <<< (23 - k)) - 1) return k;
        end
        return 0;
    endfunction

    function automatic int pack_ref(input int x);
        int e = exp_of(x);
        int m;
        if (e == 12) m = x & 32'h7FF;
        else         m = ((x * (1 <<< e)) >>> 11) & 32'h7FF;
        return (((x < 0) ? 1 : 0) << 15) | (e << 11) | m;
    endfunction

    function automatic int unpack_ref(input int w);
        int s = (w >> 15) & 1;
        int e = (w >> 11) & 15;
        int m = w & 32'h7FF;
        int base;
        if (e <= 11) base = (s != 0 ? -(1 <<< 23) : (1 <<< 22)) + m * 2048;
        else         base = (s != 0 ? -(1 <<< 22) : 0) + m * 2048;
        return base >>> ((e > 11) ? 11 : e);
    endfunction

    function automatic int sx24(input logic [23:0] v);
        return int'($signed(v));
    endfunction

    // Compress x, check it (R2-R6), then expand the word back (R10) while
    // the compress input is idle with other data (R9).
    task automatic pack_round(input int x);
        int w;
        int e;
        int keep;
        @(negedge clk);
        cmp_vld_i = 1'b1;
        cmp_smp_i = x[23:0];
        @(negedge clk);
        cmp_vld_i = 1'b0;
        cmp_smp_i = ~x[23:0];
        w = pack_ref(x);
        chk("R2 cmp valid", int'(cmp_vld_o), 1);
        chk("R3 sign", int'(cmp_word_o[15]), (w >> 15) & 1);
        chk("R4 exponent", int'(cmp_word_o[14:11]), (w >> 11) & 15);
        if (((w >> 11) & 15) == 12) chk("R6 mantissa", int'(cmp_word_o[10:0]), w & 32'h7FF);
        else                         chk("R5 mantissa", int'(cmp_word_o[10:0]), w & 32'h7FF);
        exp_vld_i  = 1'b1;
        exp_word_i = cmp_word_o;
        @(negedge clk);
        exp_vld_i = 1'b0;
        chk("R2 cmp valid drop", int'(cmp_vld_o), 0);
        chk("R9 cmp hold", int'(cmp_word_o), w);
        e = exp_of(x);
        keep = (e >= 11) ? x : ((x >>> (11 - e)) <<< (11 - e));
        chk("R10 round trip", sx24(exp_smp_o), keep);
    endtask

    initial begin
        int seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cmp valid", int'(cmp_vld_o), 0);
        chk("R1 exp valid", int'(exp_vld_o), 0);
        chk("R1 cmp word", int'(cmp_word_o), 0);
        chk("R1 exp sample", int'(exp_smp_o), 0);
        rst_n = 1'b1;

        // Edge samples: zero, full scale, powers of two and neighbours
        pack_round(0);
        pack_round(32'h007F_FFFF);
        pack_round(-32'sd8388608);
        for (int k = 0; k < 23; k++) begin
            pack_round(1 <<< k);
            pack_round((1 <<< k) - 1);
            pack_round(-(1 <<< k));
            pack_round(-(1 <<< k) - 1);
        end
        // Pseudo-random samples spread over every exponent
        for (int i = 0; i < 16384; i++) begin
            int x;
            seed = seed * 1664525 + 1013904223;
            x = (int'($signed(seed[31:8]))) >>> (i % 24);
            pack_round(x);
        end

        // Expand sweep over all words, one per cycle (R7, R8, R2)
        for (int w = 0; w <= 65536; w++) begin
            @(negedge clk);
            if (w > 0) begin
                if (((w - 1) >> 11 & 15) > 11)
                    chk("R8 clamped expand", sx24(exp_smp_o), unpack_ref(w - 1));
                else
                    chk("R7 expand", sx24(exp_smp_o), unpack_ref(w - 1));
                chk("R2 exp valid", int'(exp_vld_o), 1);
            end
            exp_vld_i  = (w < 65536);
            exp_word_i = w[15:0];
        end
        // R9: expand output holds while idle with different input
        exp_word_i = 16'h1234;
        @(negedge clk);
        chk("R2 exp valid drop", int'(exp_vld_o), 0);
        chk("R9 exp hold", sx24(exp_smp_o), unpack_ref(65535));

        // R1: reset again mid-run clears loaded values
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 cmp word after reset", int'(cmp_word_o), 0);
        chk("R1 exp sample after reset", int'(exp_smp_o), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule